// File: doc/BRIEF.md
# Windowed Address Translator

This block converts addresses in both directions for a memory-mapped serial bridge. Outbound, a local bus address is reduced to its low 26 bits and a programmable base is removed from it. The result is a zero-relative link address. Inbound, a link address is matched against four windows placed back to back from address zero. Each window has a programmable length. The address is then moved into local space by that window's programmable offset. An address that falls past the last enabled window is reported as a miss.

Both directions produce one registered result per valid input, one clock later. Configuration arrives on a single write port that selects the base, a window length or a window offset. A write changes translations that start in the next cycle. It never changes a result already in its output register.

Top module: `addr_xlate`

## Requirements
- R1: A transmit request with `tx_valid_i` high yields `tx_addr_o = (tx_addr_i[25:0] - base) mod 2^26`, where `base` is the 26-bit value last written with `cfg_sel = 0`; bits [31:26] of the request address have no effect.
- R2: After reset the base is 0, so a transmit request returns `tx_addr_i[25:0]` unchanged.
- R3: Window k (k = 0..3) spans link addresses [S_k, S_k + L_k), where L_k is its length and S_k is the sum of the lengths of windows 0..k-1; sums are exact, with no wrap at 2^32.
- R4: A receive address `a` inside window k gives `rx_hit_o = 1`, `rx_miss_o = 0`, `rx_win_o = k` (binary window index) and `rx_addr_o = (offset_k + a - S_k) mod 2^32`.
- R5: A window of length 0 matches nothing, and the windows after it start where it would have started.
- R6: A receive address at or beyond the sum of all lengths, or any address when every length is 0, gives `rx_miss_o = 1`, `rx_hit_o = 0` and `rx_addr_o = 0`.
- R7: Lengths and offsets are word aligned: bits [1:0] of the written data are ignored for `cfg_sel` 1 to 8, so the two low bits of a hit address pass through unchanged.
- R8: `tx_valid_o` and `rx_valid_o` are high exactly one cycle after `tx_valid_i` and `rx_valid_i` respectively, and they are low during reset and after cycles without a request.
- R9: A configuration write takes effect for requests presented in the cycle after the write; a request presented in the same cycle as the write uses the previous settings.
- R10: `cfg_sel` selects 0 = base, 1..4 = length of window 0..3, 5..8 = offset of window 0..3; a write with any other `cfg_sel` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| tx_valid_i | input | 1 | Transmit request valid |
| tx_addr_i | input | 32 | Local bus address to send |
| tx_valid_o | output | 1 | Transmit result valid |
| tx_addr_o | output | 26 | Zero-relative link address |
| rx_valid_i | input | 1 | Receive request valid |
| rx_addr_i | input | 32 | Incoming link address |
| rx_valid_o | output | 1 | Receive result valid |
| rx_hit_o | output | 1 | Address fell inside a window |
| rx_miss_o | output | 1 | Address fell outside all windows |
| rx_win_o | output | 2 | Index of the matching window |
| rx_addr_o | output | 32 | Translated local address, 0 on a miss |

## Verification
The assertions check on every cycle that both directions have a one-cycle latency, that hit and miss exclude each other on every result, and that at most one window claims an address. They also check that a miss returns a zero address and that a hit keeps the two low address bits. Only the bench scenarios can show that the arithmetic is correct. These scenarios cover window boundaries, a disabled window that shifts its successors, window sums past 2^32, base wrap-around, a write colliding with a request, and writes to unused selects. Each of them is compared against a behavioural model on every clock.

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  parameter int LW   = 26,
  parameter int SW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            tx_valid_i,
  input  logic [AW-1:0]   tx_addr_i,
  output logic            tx_valid_o,
  output logic [LW-1:0]   tx_addr_o,
  input  logic            rx_valid_i,
  input  logic [AW-1:0]   rx_addr_i,
  output logic            rx_valid_o,
  output logic            rx_hit_o,
  output logic            rx_miss_o,
  output logic [$clog2(NWIN)-1:0] rx_win_o,
  output logic [AW-1:0]   rx_addr_o
);
  localparam int IW   = $clog2(NWIN);
  localparam int SUMW = AW + IW;

  logic [LW-1:0]   base_q;
  logic [AW-1:2]   len_q [NWIN];
  logic [AW-1:2]   off_q [NWIN];
  logic [SUMW-1:0] start [NWIN+1];
  logic [NWIN-1:0] hit_v;
  logic [IW-1:0]   win_idx;
  logic [AW-1:0]   local_a;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (cfg_we && cfg_sel == SW'(0)) base_q <= cfg_wdata[LW-1:0];
  end

  assign start[0] = '0;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        len_q[w] <= '0;
        off_q[w] <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == SW'(w + 1))        len_q[w] <= cfg_wdata[AW-1:2];
        if (cfg_sel == SW'(NWIN + 1 + w)) off_q[w] <= cfg_wdata[AW-1:2];
      end
    end

    assign start[w+1] = start[w] + SUMW'({len_q[w], 2'b00});
    assign hit_v[w]   = (len_q[w] != '0)
                      && (SUMW'(rx_addr_i) >= start[w])
                      && (SUMW'(rx_addr_i) <  start[w+1]);
  end

  always_comb begin
    win_idx = '0;
    local_a = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit_v[w]) begin
        win_idx = IW'(w);
        local_a = {off_q[w], 2'b00} + rx_addr_i - start[w][AW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_o <= 1'b0;
      tx_addr_o  <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) tx_addr_o <= tx_addr_i[LW-1:0] - base_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_hit_o   <= 1'b0;
      rx_miss_o  <= 1'b0;
      rx_win_o   <= '0;
      rx_addr_o  <= '0;
    end else begin
      rx_valid_o <= rx_valid_i;
      rx_hit_o   <= rx_valid_i && (hit_v != '0);
      rx_miss_o  <= rx_valid_i && (hit_v == '0);
      if (rx_valid_i) begin
        rx_win_o  <= win_idx;
        rx_addr_o <= (hit_v != '0) ? local_a : '0;
      end
    end
  end

  // R8
  tx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i |=> tx_valid_o);
  // R8
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_i |=> !tx_valid_o);
  // R8
  rx_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> rx_valid_o);
  // R8
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> !rx_valid_o);
  // R4
  hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (rx_hit_o != rx_miss_o));
  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_miss_o |-> (rx_addr_o == '0 && !rx_hit_o));
  // R3
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));
  // R7
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && hit_v != '0) |=> (rx_addr_o[1:0] == $past(rx_addr_i[1:0])));
endmodule

// File: tb/tb_addr_xlate.sv
module tb_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tx_valid_i = 1'b0;
  logic [31:0] tx_addr_i = '0;
  logic        rx_valid_i = 1'b0;
  logic [31:0] rx_addr_i = '0;
  logic        tx_valid_o, rx_valid_o, rx_hit_o, rx_miss_o;
  logic [25:0] tx_addr_o;
  logic [1:0]  rx_win_o;
  logic [31:0] rx_addr_o;

  addr_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tx_valid_i(tx_valid_i), .tx_addr_i(tx_addr_i), .tx_valid_o(tx_valid_o), .tx_addr_o(tx_addr_o),
    .rx_valid_i(rx_valid_i), .rx_addr_i(rx_addr_i), .rx_valid_o(rx_valid_o), .rx_hit_o(rx_hit_o),
    .rx_miss_o(rx_miss_o), .rx_win_o(rx_win_o), .rx_addr_o(rx_addr_o));

  always #2 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R8";
  bit    done = 1'b0;

  longint m_base;
  longint m_len [4];
  longint m_off [4];
  bit     e_txv, e_rxv, e_hit, e_miss;
  longint e_tx, e_rx, e_win;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0;
      for (int k = 0; k < 4; k++) begin m_len[k] = 0; m_off[k] = 0; end
      e_txv = 0; e_rxv = 0; e_hit = 0; e_miss = 0;
    end else begin
      e_txv = tx_valid_i;
      if (tx_valid_i) e_tx = (longint'(tx_addr_i) % 64'h400_0000 - m_base + 64'h400_0000) % 64'h400_0000;
      e_rxv = rx_valid_i;
      e_hit = 0; e_miss = 0;
      if (rx_valid_i) begin
        longint a, st;
        a = longint'(rx_addr_i);
        st = 0;
        e_rx = 0; e_win = 0;
        for (int k = 0; k < 4; k++) begin
          if (!e_hit && m_len[k] != 0 && a >= st && a < st + m_len[k]) begin
            e_hit = 1;
            e_win = k;
            e_rx = (m_off[k] + a - st + 64'h1_0000_0000) % 64'h1_0000_0000;
          end
          st = st + m_len[k];
        end
        e_miss = !e_hit;
      end
      if (cfg_we) begin
        if (cfg_sel == 0) m_base = longint'(cfg_wdata) % 64'h400_0000;
        else if (cfg_sel <= 4) m_len[cfg_sel-1] = longint'(cfg_wdata) & 64'hFFFF_FFFC;
        else if (cfg_sel <= 8) m_off[cfg_sel-5] = longint'(cfg_wdata) & 64'hFFFF_FFFC;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R8", "tx_valid_o in reset", longint'(tx_valid_o), 0);
      chk("R8", "rx_valid_o in reset", longint'(rx_valid_o), 0);
    end else if (!done) begin
      chk("R8", "tx_valid_o", longint'(tx_valid_o), longint'(e_txv));
      chk("R8", "rx_valid_o", longint'(rx_valid_o), longint'(e_rxv));
      if (e_txv) chk(cur_req, "tx_addr_o", longint'(tx_addr_o), e_tx);
      if (e_rxv) begin
        chk(cur_req, "rx_hit_o", longint'(rx_hit_o), longint'(e_hit));
        chk(cur_req, "rx_miss_o", longint'(rx_miss_o), longint'(e_miss));
        chk(cur_req, "rx_addr_o", longint'(rx_addr_o), e_rx);
        if (e_hit) chk(cur_req, "rx_win_o", longint'(rx_win_o), e_win);
      end
    end
  end

  task automatic cyc(bit we, logic [3:0] sel, logic [31:0] d,
                     bit tv, logic [31:0] ta, bit rv, logic [31:0] ra);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    tx_valid_i = tv; tx_addr_i = ta;
    rx_valid_i = rv; rx_addr_i = ra;
  endtask
  task automatic wr(logic [3:0] sel, logic [31:0] d); cyc(1, sel, d, 0, 0, 0, 0); endtask
  task automatic tx(logic [31:0] a); cyc(0, 0, 0, 1, a, 0, 0); endtask
  task automatic rx(logic [31:0] a); cyc(0, 0, 0, 0, 0, 1, a); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R2";
    tx(32'h0123_4567); tx(32'hFFFF_FFFF); idle();
    cur_req = "R1";
    wr(0, 32'h0010_0000);
    tx(32'h0030_0000); tx(32'h0008_0000); tx(32'hFC30_0000); idle();
    cur_req = "R6";
    rx(32'h0); rx(32'h1234_5678); idle();
    cur_req = "R3";
    wr(1, 32'h1000); wr(2, 32'h2000); wr(3, 32'h400); wr(4, 32'h800);
    wr(5, 32'h8000_0000); wr(6, 32'h4000_0000); wr(7, 32'h100); wr(8, 32'h9000_0000);
    rx(32'h0); rx(32'hFFC); rx(32'h1000); rx(32'h2FFC);
    cur_req = "R4";
    rx(32'h3000); rx(32'h33FF); rx(32'h3400); rx(32'h3BFD);
    cur_req = "R6";
    rx(32'h3C00); rx(32'hFFFF_FFFC); idle();
    cur_req = "R5";
    wr(2, 32'h0);
    rx(32'h1000); rx(32'h13FC); rx(32'h1800); rx(32'h1C00); idle();
    cur_req = "R7";
    wr(1, 32'h1003); wr(5, 32'h8000_0003);
    rx(32'h0FFF); rx(32'h1000); rx(32'h0003); idle();
    cur_req = "R9";
    cyc(1, 4'd1, 32'h10, 0, 0, 1, 32'h800);
    rx(32'h800); rx(32'h0C); rx(32'h10); idle();
    cur_req = "R10";
    wr(4'd15, 32'hFFFF_FFFF); wr(4'd9, 32'h0);
    rx(32'h800); rx(32'h0C); tx(32'h0030_0000); idle();
    cur_req = "R3";
    wr(1, 32'hC000_0000); wr(2, 32'hC000_0000); wr(3, 32'h0); wr(4, 32'h0);
    rx(32'hBFFF_FFFC); rx(32'hC000_0000); rx(32'hFFFF_FFFC);
    cyc(0, 0, 0, 1, 32'h0000_0004, 1, 32'h1234_0000); idle();
    cur_req = "R6";
    wr(1, 32'h0); wr(2, 32'h0);
    rx(32'h0); idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule